// File: doc/BRIEF.md
# Explicit Rate Feedback Calculator

This block computes explicit-rate feedback for one output port of a cell switch that carries rate-controlled best-effort traffic. Time is split into averaging intervals. At the end of each interval an upstream measurement unit delivers one summary: the input cell count, the link capacity, the capacity used by higher-priority traffic, a capacity fraction and the number of active connections. From it the block derives a target capacity, a load factor, a fair share and two maximum-allocation registers, one for the interval that just ended and one for the interval now running.

Forward resource-management cells carry a connection's current cell rate. The block stores that rate in a small per-connection table. For each backward resource-management cell, the block reads the stored rate and divides it by the load factor to get the connection's share. It then picks a rate according to the load band and holds a slow connection down to the fair share. The rate it returns is never above the ER field carried in the cell or the target capacity.

All three inputs use valid/ready handshakes. The results go out as a one-cycle pulse. Every division runs on one shared sequential divider, so the block takes a single request at a time.

Top module: `er_feedback_calc`

## Requirements
- R1: After reset, all three ready outputs are high, erValid is low, and the fair share, both maximum-allocation registers, the smoothed rates and the rate table are zero. A backward request issued before any interval summary therefore returns rate 0.
- R2: ABR capacity is link capacity minus priority capacity, floored at zero when the priority capacity is larger. Target capacity is (smoothed capacity × fraction) >> 16, with the fraction unsigned Q0.16 and the result truncated.
- R3: Input count and ABR capacity are each smoothed as (A·sample + (65536−A)·previous) >> 16. A is ALPHA_Q, default 52429 (about 0.8), and both previous values start at zero.
- R4: The load factor is unsigned Q8.16, equal to (smoothed input << 16) / target, truncated and saturated at 0xFFFFFF. A zero target gives 0xFFFFFF.
- R5: The fair share is target / active count, truncated. An active count of zero gives a fair share equal to the target.
- R6: When an interval summary completes, the previous-maximum register takes the current-maximum value, and the current-maximum register and the fair share both take the new fair share. The load factor takes its new value at the same point.
- R7: A forward request writes its rate field into the table entry indexed by its connection number. Later backward requests for that connection use the new value.
- R8: The connection share is (stored rate << 16) / load factor, saturated at 0xFFFFFF, and a zero load factor gives 0xFFFFFF. If the load factor is above 65536+DELTA_Q (default 6554), the chosen rate is max(fair share, share). Otherwise it is max(previous maximum, share).
- R9: Each backward request raises the current-maximum register to max(itself, chosen rate). This uses the chosen rate before any later reduction.
- R10: If the chosen rate is above the fair share and the stored rate is below the fair share, the rate becomes the fair share.
- R11: The returned rate is the minimum of the R10 result, the ER field of the cell and the target. It appears on erRate with erValid high for exactly one cycle per backward request.
- R12: The ready outputs are high only while the block is idle. Priority is interval summary, then backward, then forward: bwdReady is low while ivValid is high, and fwdReady is low while ivValid or bwdValid is high. All ready outputs are low in the cycle after an accepted interval summary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ivValid | input | 1 | Interval summary valid |
| ivReady | output | 1 | Interval summary accepted when high with ivValid |
| ivInCount | input | RATE_W | Measured input rate for the interval |
| ivLinkCap | input | RATE_W | Link capacity |
| ivPrioCap | input | RATE_W | Capacity used by higher-priority traffic |
| ivFraction | input | LF_FRAC | Target fraction, unsigned Q0.16 |
| ivActive | input | CNT_W | Active connection count |
| fwdValid | input | 1 | Forward rate update valid |
| fwdReady | output | 1 | Forward update accepted |
| fwdVc | input | log2(NUM_VC) | Connection index of the forward update |
| fwdCcr | input | RATE_W | Current cell rate from the forward cell |
| bwdValid | input | 1 | Backward request valid |
| bwdReady | output | 1 | Backward request accepted |
| bwdVc | input | log2(NUM_VC) | Connection index of the backward request |
| bwdEr | input | RATE_W | ER field carried in the backward cell |
| erValid | output | 1 | One-cycle pulse marking a returned rate |
| erRate | output | RATE_W | Returned explicit rate |

## Verification
The bench builds the block with 24-bit rates, a Q8.16 load factor, eight connections and the default smoothing weight and band width. With these values both load bands can be reached through the ordinary input counts. A run of intervals with priority capacity above link capacity drives the smoothed capacity to zero within eight intervals, which brings the saturated load factor and a zero target into reach. The reference model tracks every register as a plain integer and predicts each returned rate. The bench compares the prediction whenever erValid rises, and it also checks the ready priority with all three requests raised at once.

// File: rtl/erfb_pkg.sv
`timescale 1ns/1ps
package erfb_pkg;

  // strobes from control to datapath, at most one sequence step per cycle
  typedef struct packed {
    logic latchIv;
    logic calcTarget;
    logic startLf;
    logic saveLf;
    logic startFs;
    logic commitIv;
    logic latchBwd;
    logic startVs;
    logic finishBwd;
    logic writeFwd;
  } strobe_t;

  typedef enum logic [3:0] {
    S_IDLE,
    S_IV_CALC,
    S_LF_START,
    S_LF_WAIT,
    S_FS_START,
    S_FS_WAIT,
    S_BW_START,
    S_BW_WAIT
  } state_t;

endpackage

// File: rtl/erfb_divider.sv
`timescale 1ns/1ps
module erfb_divider #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] dividend,
  input  logic [DEN_W-1:0] divisor,
  output logic             done,
  output logic [NUM_W-1:0] quotient
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den;
  logic [NUM_W-1:0] quo;
  logic [DEN_W:0]   trial;
  logic             fits;

  // restoring division; a zero divisor yields an all-ones quotient
  always_comb begin
    trial = {rem, quo[NUM_W-1]};
    fits  = trial >= {1'b0, den};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
      cnt  <= '0;
      rem  <= '0;
      den  <= '0;
      quo  <= '0;
      done <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(NUM_W);
      rem  <= '0;
      den  <= divisor;
      quo  <= dividend;
      done <= 1'b0;
    end else if (busy) begin
      rem  <= fits ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
      quo  <= {quo[NUM_W-2:0], fits};
      cnt  <= cnt - CNT_W'(1);
      busy <= (cnt != CNT_W'(1));
      done <= (cnt == CNT_W'(1));
    end else begin
      done <= 1'b0;
    end
  end

  assign quotient = quo;

  // R4 R5 R8: every division started is actually run
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    start |=> busy);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/erfb_ctrl.sv
`timescale 1ns/1ps
module erfb_ctrl
  import erfb_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    ivValid,
  input  logic    bwdValid,
  input  logic    fwdValid,
  input  logic    divDone,
  output logic    ivReady,
  output logic    bwdReady,
  output logic    fwdReady,
  output strobe_t st
);
  state_t state, nextState;
  logic   idle;

  assign idle     = (state == S_IDLE);
  assign ivReady  = idle;
  assign bwdReady = idle && !ivValid;
  assign fwdReady = idle && !ivValid && !bwdValid;

  always_comb begin
    st        = '0;
    nextState = state;
    case (state)
      S_IDLE: begin
        if (ivValid) begin
          st.latchIv = 1'b1;
          nextState  = S_IV_CALC;
        end else if (bwdValid) begin
          st.latchBwd = 1'b1;
          nextState   = S_BW_START;
        end else if (fwdValid) begin
          st.writeFwd = 1'b1;
        end
      end
      S_IV_CALC: begin
        st.calcTarget = 1'b1;
        nextState     = S_LF_START;
      end
      S_LF_START: begin
        st.startLf = 1'b1;
        nextState  = S_LF_WAIT;
      end
      S_LF_WAIT: begin
        if (divDone) begin
          st.saveLf = 1'b1;
          nextState = S_FS_START;
        end
      end
      S_FS_START: begin
        st.startFs = 1'b1;
        nextState  = S_FS_WAIT;
      end
      S_FS_WAIT: begin
        if (divDone) begin
          st.commitIv = 1'b1;
          nextState   = S_IDLE;
        end
      end
      S_BW_START: begin
        st.startVs = 1'b1;
        nextState  = S_BW_WAIT;
      end
      S_BW_WAIT: begin
        if (divDone) begin
          st.finishBwd = 1'b1;
          nextState    = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R12: an accepted summary blocks every port in the following cycle
  p_busy_after_iv_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ivValid && ivReady) |=> (!ivReady && !bwdReady && !fwdReady));
  // R12: at most one request is taken per cycle
  p_single_accept_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ivValid && ivReady, bwdValid && bwdReady, fwdValid && fwdReady}));

endmodule

// File: rtl/erfb_datapath.sv
`timescale 1ns/1ps
module erfb_datapath
  import erfb_pkg::*;
#(
  parameter int RATE_W  = 24,
  parameter int LF_FRAC = 16,
  parameter int CNT_W   = 8,
  parameter int NUM_VC  = 16,
  parameter int ALPHA_Q = 52429,
  parameter int DELTA_Q = 6554
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobe_t                    st,
  input  logic [RATE_W-1:0]          ivInCount,
  input  logic [RATE_W-1:0]          ivLinkCap,
  input  logic [RATE_W-1:0]          ivPrioCap,
  input  logic [LF_FRAC-1:0]         ivFraction,
  input  logic [CNT_W-1:0]           ivActive,
  input  logic [$clog2(NUM_VC)-1:0]  fwdVc,
  input  logic [RATE_W-1:0]          fwdCcr,
  input  logic [$clog2(NUM_VC)-1:0]  bwdVc,
  input  logic [RATE_W-1:0]          bwdEr,
  output logic                       divDone,
  output logic                       erValid,
  output logic [RATE_W-1:0]          erRate
);
  localparam int VC_W   = $clog2(NUM_VC);
  localparam int NUM_W  = RATE_W + LF_FRAC;
  localparam int ACC_W  = RATE_W + LF_FRAC + 2;
  localparam int PROD_W = RATE_W + LF_FRAC;
  localparam int W_ONE  = 1 << LF_FRAC;
  localparam logic [LF_FRAC:0]  A_K  = (LF_FRAC + 1)'(ALPHA_Q);
  localparam logic [LF_FRAC:0]  B_K  = (LF_FRAC + 1)'(W_ONE - ALPHA_Q);
  localparam logic [RATE_W-1:0] BAND = RATE_W'(W_ONE + DELTA_Q);
  localparam logic [RATE_W-1:0] RATE_MAX = '1;

  // latched interval summary
  logic [RATE_W-1:0]  inCntR, linkR, prioR;
  logic [LF_FRAC-1:0] fracR;
  logic [CNT_W-1:0]   activeR;
  // interval state
  logic [RATE_W-1:0]  emaIn, emaCap, target, lfNew, lf, fairShare, maxPrev, maxCur;
  // backward request state
  logic [RATE_W-1:0]  ccrR, cellErR;

  // per-connection rate table
  logic [RATE_W-1:0]  tabOut [NUM_VC];
  for (genvar g = 0; g < NUM_VC; g++) begin : g_tab
    logic [RATE_W-1:0] entry;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        entry <= '0;
      else if (st.writeFwd && fwdVc == VC_W'(g))
        entry <= fwdCcr;
    end
    assign tabOut[g] = entry;
  end

  // capacity, smoothing and target
  logic [RATE_W-1:0] totalCap, emaInNext, emaCapNext, targetNext;
  always_comb begin
    totalCap   = (linkR > prioR) ? (linkR - prioR) : '0;
    emaInNext  = RATE_W'((ACC_W'(A_K) * ACC_W'(inCntR) + ACC_W'(B_K) * ACC_W'(emaIn)) >> LF_FRAC);
    emaCapNext = RATE_W'((ACC_W'(A_K) * ACC_W'(totalCap) + ACC_W'(B_K) * ACC_W'(emaCap)) >> LF_FRAC);
    targetNext = RATE_W'((PROD_W'(emaCapNext) * PROD_W'(fracR)) >> LF_FRAC);
  end

  // shared divider and its operand selection
  logic             divStart;
  logic [NUM_W-1:0] dividend, quotient;
  logic [RATE_W-1:0] divisor, quoSat;
  always_comb begin
    divStart = st.startLf | st.startFs | st.startVs;
    if (st.startLf) begin
      dividend = {emaIn, LF_FRAC'(0)};
      divisor  = target;
    end else if (st.startFs) begin
      dividend = NUM_W'(target);
      divisor  = RATE_W'(activeR);
    end else begin
      dividend = {ccrR, LF_FRAC'(0)};
      divisor  = lf;
    end
    quoSat = (|quotient[NUM_W-1:RATE_W]) ? RATE_MAX : quotient[RATE_W-1:0];
  end

  erfb_divider #(.NUM_W(NUM_W), .DEN_W(RATE_W)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .start   (divStart),
    .dividend(dividend),
    .divisor (divisor),
    .done    (divDone),
    .quotient(quotient)
  );

  // rate selection for a backward request
  logic [RATE_W-1:0] fsNew, chosen, held, clamped;
  logic              hiBand;
  always_comb begin
    fsNew   = (activeR == '0) ? target : quoSat;
    hiBand  = lf > BAND;
    if (hiBand) chosen = (fairShare > quoSat) ? fairShare : quoSat;
    else        chosen = (maxPrev   > quoSat) ? maxPrev   : quoSat;
    held    = (chosen > fairShare && ccrR < fairShare) ? fairShare : chosen;
    clamped = (held < cellErR) ? held : cellErR;
    if (target < clamped) clamped = target;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCntR    <= '0;
      linkR     <= '0;
      prioR     <= '0;
      fracR     <= '0;
      activeR   <= '0;
      emaIn     <= '0;
      emaCap    <= '0;
      target    <= '0;
      lfNew     <= '0;
      lf        <= '0;
      fairShare <= '0;
      maxPrev   <= '0;
      maxCur    <= '0;
      ccrR      <= '0;
      cellErR   <= '0;
      erValid   <= 1'b0;
      erRate    <= '0;
    end else begin
      erValid <= 1'b0;
      if (st.latchIv) begin
        inCntR  <= ivInCount;
        linkR   <= ivLinkCap;
        prioR   <= ivPrioCap;
        fracR   <= ivFraction;
        activeR <= ivActive;
      end
      if (st.calcTarget) begin
        emaIn  <= emaInNext;
        emaCap <= emaCapNext;
        target <= targetNext;
      end
      if (st.saveLf) lfNew <= quoSat;
      if (st.commitIv) begin
        lf        <= lfNew;
        fairShare <= fsNew;
        maxPrev   <= maxCur;
        maxCur    <= fsNew;
      end
      if (st.latchBwd) begin
        ccrR    <= tabOut[bwdVc];
        cellErR <= bwdEr;
      end
      if (st.finishBwd) begin
        if (chosen > maxCur) maxCur <= chosen;
        erRate  <= clamped;
        erValid <= 1'b1;
      end
    end
  end

  // R11: returned rate respects both ceilings
  p_er_le_target_r11: assert property (@(posedge clk) disable iff (!rstN)
    erValid |-> (erRate <= target));
  p_er_le_cell_r11: assert property (@(posedge clk) disable iff (!rstN)
    erValid |-> (erRate <= cellErR));
  // R9: the running maximum never drops below the fair share
  p_maxcur_ge_fs_r9: assert property (@(posedge clk) disable iff (!rstN)
    maxCur >= fairShare);
  // R6: the interval roll-over hands the running maximum on
  p_rollover_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.commitIv |=> (maxPrev == $past(maxCur)));

endmodule

// File: rtl/er_feedback_calc.sv
`timescale 1ns/1ps
module er_feedback_calc
  import erfb_pkg::*;
#(
  parameter int RATE_W  = 24,
  parameter int LF_FRAC = 16,
  parameter int CNT_W   = 8,
  parameter int NUM_VC  = 16,
  parameter int ALPHA_Q = 52429,
  parameter int DELTA_Q = 6554
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      ivValid,
  output logic                      ivReady,
  input  logic [RATE_W-1:0]         ivInCount,
  input  logic [RATE_W-1:0]         ivLinkCap,
  input  logic [RATE_W-1:0]         ivPrioCap,
  input  logic [LF_FRAC-1:0]        ivFraction,
  input  logic [CNT_W-1:0]          ivActive,
  input  logic                      fwdValid,
  output logic                      fwdReady,
  input  logic [$clog2(NUM_VC)-1:0] fwdVc,
  input  logic [RATE_W-1:0]         fwdCcr,
  input  logic                      bwdValid,
  output logic                      bwdReady,
  input  logic [$clog2(NUM_VC)-1:0] bwdVc,
  input  logic [RATE_W-1:0]         bwdEr,
  output logic                      erValid,
  output logic [RATE_W-1:0]         erRate
);
  strobe_t st;
  logic    divDone;

  erfb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ivValid (ivValid),
    .bwdValid(bwdValid),
    .fwdValid(fwdValid),
    .divDone (divDone),
    .ivReady (ivReady),
    .bwdReady(bwdReady),
    .fwdReady(fwdReady),
    .st      (st)
  );

  erfb_datapath #(
    .RATE_W (RATE_W),
    .LF_FRAC(LF_FRAC),
    .CNT_W  (CNT_W),
    .NUM_VC (NUM_VC),
    .ALPHA_Q(ALPHA_Q),
    .DELTA_Q(DELTA_Q)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .ivInCount (ivInCount),
    .ivLinkCap (ivLinkCap),
    .ivPrioCap (ivPrioCap),
    .ivFraction(ivFraction),
    .ivActive  (ivActive),
    .fwdVc     (fwdVc),
    .fwdCcr    (fwdCcr),
    .bwdVc     (bwdVc),
    .bwdEr     (bwdEr),
    .divDone   (divDone),
    .erValid   (erValid),
    .erRate    (erRate)
  );

endmodule

// File: tb/er_feedback_calc_tb.sv
`timescale 1ns/1ps
module er_feedback_calc_tb;
  localparam int     RW = 24;
  localparam int     FR = 16;
  localparam int     CW = 8;
  localparam int     NV = 8;
  localparam int     VW = 3;
  localparam longint ALPHA = 52429;
  localparam longint DELTA = 6554;
  localparam longint ONE   = 65536;
  localparam longint MAXR  = (longint'(1) << RW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          ivValid = 0, fwdValid = 0, bwdValid = 0;
  logic          ivReady, fwdReady, bwdReady, erValid;
  logic [RW-1:0] ivInCount = 0, ivLinkCap = 0, ivPrioCap = 0, fwdCcr = 0, bwdEr = 0, erRate;
  logic [FR-1:0] ivFraction = 0;
  logic [CW-1:0] ivActive = 0;
  logic [VW-1:0] fwdVc = 0, bwdVc = 0;

  er_feedback_calc #(.RATE_W(RW), .LF_FRAC(FR), .CNT_W(CW), .NUM_VC(NV),
                     .ALPHA_Q(52429), .DELTA_Q(6554)) u_dut (
    .clk(clk), .rstN(rstN),
    .ivValid(ivValid), .ivReady(ivReady), .ivInCount(ivInCount), .ivLinkCap(ivLinkCap),
    .ivPrioCap(ivPrioCap), .ivFraction(ivFraction), .ivActive(ivActive),
    .fwdValid(fwdValid), .fwdReady(fwdReady), .fwdVc(fwdVc), .fwdCcr(fwdCcr),
    .bwdValid(bwdValid), .bwdReady(bwdReady), .bwdVc(bwdVc), .bwdEr(bwdEr),
    .erValid(erValid), .erRate(erRate));

  int total = 0;
  int bad = 0;

  // behavioural reference state
  longint mEmaIn = 0, mEmaCap = 0, mTarget = 0, mLf = 0, mFs = 0, mMaxPrev = 0, mMaxCur = 0;
  longint mCcr [NV];
  longint expQ [$];
  string  tagQ [$];

  function automatic longint lmax(longint a, longint b); return (a > b) ? a : b; endfunction
  function automatic longint lmin(longint a, longint b); return (a < b) ? a : b; endfunction

  task automatic check(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compared on every clock: each pulse must match the oldest prediction
  always @(negedge clk) begin
    if (rstN && erValid) begin
      if (expQ.size() == 0) begin
        total++;
        bad++;
        $display("FAIL R11 unexpected pulse: actual=%0d expected=none", erRate);
      end else begin
        check(tagQ.pop_front(), longint'(erRate), expQ.pop_front());
      end
    end
  end

  task automatic sendIv(longint inC, longint link, longint prio, longint frac, longint act);
    longint tot, fsNew;
    @(negedge clk);
    ivInCount = RW'(inC); ivLinkCap = RW'(link); ivPrioCap = RW'(prio);
    ivFraction = FR'(frac); ivActive = CW'(act); ivValid = 1'b1;
    #1;
    while (!ivReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    ivValid = 1'b0;
    tot      = (link > prio) ? link - prio : 0;
    mEmaIn   = (ALPHA * inC + (ONE - ALPHA) * mEmaIn) >> 16;
    mEmaCap  = (ALPHA * tot + (ONE - ALPHA) * mEmaCap) >> 16;
    mTarget  = (mEmaCap * frac) >> 16;
    mLf      = (mTarget == 0) ? MAXR : lmin((mEmaIn << 16) / mTarget, MAXR);
    fsNew    = (act == 0) ? mTarget : mTarget / act;
    mMaxPrev = mMaxCur;
    mMaxCur  = fsNew;
    mFs      = fsNew;
  endtask

  task automatic sendFwd(int vc, longint ccr);
    @(negedge clk);
    fwdVc = VW'(vc); fwdCcr = RW'(ccr); fwdValid = 1'b1;
    #1;
    while (!fwdReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    fwdValid = 1'b0;
    mCcr[vc] = ccr;
  endtask

  task automatic sendBwd(int vc, longint er, string tag);
    longint ccr, vs, chosen, held;
    @(negedge clk);
    bwdVc = VW'(vc); bwdEr = RW'(er); bwdValid = 1'b1;
    #1;
    while (!bwdReady) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    bwdValid = 1'b0;
    ccr    = mCcr[vc];
    vs     = (mLf == 0) ? MAXR : lmin((ccr << 16) / mLf, MAXR);
    chosen = (mLf > ONE + DELTA) ? lmax(mFs, vs) : lmax(mMaxPrev, vs);
    mMaxCur = lmax(mMaxCur, chosen);
    held   = (chosen > mFs && ccr < mFs) ? mFs : chosen;
    expQ.push_back(lmin(lmin(held, er), mTarget));
    tagQ.push_back(tag);
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < NV; i++) mCcr[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1 ivReady after reset", longint'(ivReady), 1);
    check("R1 bwdReady after reset", longint'(bwdReady), 1);
    check("R1 fwdReady after reset", longint'(fwdReady), 1);
    check("R1 erValid after reset", longint'(erValid), 0);

    sendBwd(0, 100000, "R1 zero registers before any interval");
    drain();

    sendFwd(0, 40000);
    sendFwd(1, 2000);
    sendFwd(2, 20000);
    sendFwd(3, 60000);
    sendFwd(4, 10000);

    // overload: high band
    sendIv(90000, 100000, 20000, 58982, 4);
    check("R12 ivReady low while busy", longint'(ivReady), 0);
    check("R12 bwdReady low while busy", longint'(bwdReady), 0);
    check("R12 fwdReady low while busy", longint'(fwdReady), 0);
    sendBwd(0, 200000, "R2 R3 R4 R8 high band share");
    sendBwd(1, 200000, "R8 high band fair share floor");
    sendIv(90000, 100000, 20000, 58982, 4);
    sendIv(90000, 100000, 20000, 58982, 4);
    sendBwd(3, 5000, "R11 cell ER clamp");
    sendBwd(2, 200000, "R3 smoothed rates converge");

    // underload: low band
    sendIv(30000, 100000, 20000, 58982, 4);
    sendBwd(0, 200000, "R8 low band previous maximum");
    sendBwd(3, 200000, "R11 target clamp and R9 raise");
    sendIv(30000, 100000, 20000, 58982, 4);
    sendBwd(1, 200000, "R6 R9 R10 slow connection held to fair share");
    sendBwd(4, 200000, "R10 second slow connection");
    sendBwd(3, 200000, "R6 previous maximum after roll-over");

    sendFwd(1, 30000);
    sendBwd(1, 200000, "R7 table write seen by backward");

    // connection count corner cases
    sendIv(200000, 100000, 20000, 58982, 0);
    sendBwd(1, 200000, "R5 zero count uses target");
    sendIv(200000, 100000, 20000, 58982, 3);
    sendBwd(4, 200000, "R5 fair share division");
    sendIv(60000, 120000, 10000, 32768, 2);
    sendBwd(2, 200000, "R2 half fraction");
    drain();

    // priority among simultaneous requests
    @(negedge clk);
    ivValid = 1'b1; bwdValid = 1'b1; fwdValid = 1'b1;
    #1;
    check("R12 ivReady wins", longint'(ivReady), 1);
    check("R12 bwdReady yields to summary", longint'(bwdReady), 0);
    check("R12 fwdReady yields to summary", longint'(fwdReady), 0);
    ivValid = 1'b0;
    #1;
    check("R12 bwdReady over forward", longint'(bwdReady), 1);
    check("R12 fwdReady yields to backward", longint'(fwdReady), 0);
    bwdValid = 1'b0; fwdValid = 1'b0;

    // capacity floor: smoothed capacity decays to zero
    for (int k = 0; k < 10; k++) sendIv(1000, 10000, 50000, 58982, 2);
    sendBwd(0, 200000, "R2 R4 zero target saturates load factor");
    sendBwd(3, 200000, "R11 zero target gives zero rate");
    drain();
    check("R11 all predictions consumed", longint'(expQ.size()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule